// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is the register side of a CMOS-style real-time clock. Software reaches it through two ports on one 8-bit bus: an address port that picks a register index, and a data port that reads or writes the register at that index. Ten time and alarm bytes sit at indices 0 to 9 and four status bytes follow them. Reset loads the time bytes from a parameter, so the clock starts at a chosen date. The block keeps the time and alarm bytes and hands them back. It does not advance seconds, match alarms or carry calendar arithmetic.

Status register A reports an update-in-progress flag that inverts after every read of A. Software polling for an edge of that flag therefore always sees one within two reads. Status register B holds the format bits and one enable for the periodic interrupt. While that enable is set, a free-running divider of `DIV_COUNT` clock cycles emits a one-cycle pulse on each wrap. The divider is a two-state machine. In PI_IDLE the divider is held at zero. The START transition goes to PI_RUN when the enable is seen set. In PI_RUN the WRAP transition stays in PI_RUN and fires the pulse, and the STOP transition returns to PI_IDLE when the enable is seen clear. Status registers C and D always read as zero.

Top module: `rtc_cmos_regs`

## Requirements
- R1: After reset the selected index is 0, the error flag is 0, status A reads 0x26 (update flag at bit 7 clear, base-select field bits 6:4 = 010, rate field bits 3:0 = 0110), status B reads 0x06, the interrupt is low, and byte i of `TIME_INIT` (bits 8i+7:8i) is held at index i for i = 0 to 9.
- R2: A write to the address port (`bus_port` = 0) with a value from 0x00 to 0x0D selects that index. A read of the address port returns {error flag, 3'b000, index[3:0]}.
- R3: A write to the address port with a value above 0x0D leaves the index unchanged and sets the error flag. The flag stays set until reset.
- R4: Data port (`bus_port` = 1) writes and reads at indices 0 to 9 store and return a full byte per index. The index order is seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, weekday, day of month, month, year. Weekday and month are 1-based, and the block stores them as given.
- R5: A read of status A (index 0x0A) returns its current value and then inverts bit 7, so consecutive reads alternate in that bit.
- R6: A write to status A replaces bits 6:0 and leaves bit 7 unchanged.
- R7: Status B (index 0x0B) stores and returns a full byte. Bit 6 is the periodic-interrupt enable, bit 2 the binary-format bit and bit 1 the 24-hour bit.
- R8: Status C (0x0C) and D (0x0D) always read 0x00, and writes to them have no effect.
- R9: While the enable bit is set, `periodic_irq` gives one-cycle pulses exactly `DIV_COUNT` cycles apart.
- R10: Once the enable bit is clear, no pulse occurs. A divider wrap that falls on the same clock edge as the write clearing the enable still gives its pulse, because the enable held before that edge governs.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = address port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| periodic_irq | output | 1 | One-cycle periodic interrupt pulse |
| index_err | output | 1 | Sticky out-of-range index flag |

## Verification
Two functions can meet on one clock edge: the divider wrap and a data-port write that clears the interrupt enable in status B. The bench provokes this by waiting for a pulse and then placing the disabling write so that it is sampled exactly `DIV_COUNT` cycles later, on the next wrap edge. The check passes if that wrap still gives its pulse and if no pulse follows over several later divider periods.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NUM_TIME_BYTES = 10;
    localparam int IDX_W          = 4;
    localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
    localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;
    localparam logic [IDX_W-1:0] IDX_STAT_C = 4'hC;
    localparam logic [IDX_W-1:0] IDX_STAT_D = 4'hD;
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_STAT_D;
    localparam int UIP_BIT = 7;
    localparam int PIE_BIT = 6;
    localparam logic [7:0] STAT_A_RESET = 8'h26;
    localparam logic [7:0] STAT_B_RESET = 8'h06;

    typedef enum logic {
        PI_IDLE = 1'b0,
        PI_RUN  = 1'b1
    } pi_state_t;
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] index,
    output logic             err
);
    logic in_range;

    always_comb begin
        in_range = (wdata <= {4'h0, IDX_LAST});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
            err   <= 1'b0;
        end else if (addr_wr) begin
            if (in_range) begin
                index <= wdata[IDX_W-1:0];
            end else begin
                err <= 1'b1;
            end
        end
    end

    // R2
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index <= IDX_LAST);

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R3
    bad_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wdata > 8'h0D) |=> (index == $past(index)));
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank #(
    parameter int          NUM_BYTES = 10,
    parameter logic [79:0] INIT      = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] sel,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte
);
    logic [7:0] bytes_q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= INIT[8*g +: 8];
            end else if (wr_en && sel == 4'(g)) begin
                bytes_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (sel == 4'(i)) rd_byte = bytes_q[i];
        end
    end
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
    import rtc_pkg::*;
#(
    parameter int DIV_COUNT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic pulse
);
    localparam int DIV_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_COUNT - 1);

    pi_state_t        state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             wrap;

    always_comb begin
        wrap    = (state_q == PI_RUN) && (div_q == DIV_LAST);
        state_d = state_q;
        unique case (state_q)
            PI_IDLE: if (enable)  state_d = PI_RUN;   // START
            PI_RUN:  if (!enable) state_d = PI_IDLE;  // STOP, else WRAP/count
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PI_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= wrap && enable;
            if (state_q != PI_RUN || !enable || wrap) div_q <= '0;
            else                                      div_q <= div_q + 1'b1;
        end
    end

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R10
    pulse_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(enable));
endmodule

// File: rtl/rtc_cmos_regs.sv
module rtc_cmos_regs
    import rtc_pkg::*;
#(
    parameter int          DIV_COUNT = 32,
    parameter logic [79:0] TIME_INIT = 80'h09_01_01_05_00_00_00_00_00_00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic       bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       periodic_irq,
    output logic       index_err
);
    logic [IDX_W-1:0] index;
    logic [7:0]       stat_a_q, stat_b_q, time_byte;
    logic             addr_wr, data_wr, data_rd, addr_rd, time_wr;

    always_comb begin
        addr_wr = bus_en &&  bus_wr && !bus_port;
        addr_rd = bus_en && !bus_wr && !bus_port;
        data_wr = bus_en &&  bus_wr &&  bus_port;
        data_rd = bus_en && !bus_wr &&  bus_port;
        time_wr = data_wr && (index < IDX_W'(NUM_TIME_BYTES));
    end

    rtc_index_port u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (addr_wr),
        .wdata   (bus_wdata),
        .index   (index),
        .err     (index_err)
    );

    rtc_time_bank #(.NUM_BYTES(NUM_TIME_BYTES), .INIT(TIME_INIT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (time_wr),
        .sel     (index),
        .wdata   (bus_wdata),
        .rd_byte (time_byte)
    );

    rtc_periodic #(.DIV_COUNT(DIV_COUNT)) u_periodic (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (stat_b_q[PIE_BIT]),
        .pulse  (periodic_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a_q <= STAT_A_RESET;
            stat_b_q <= STAT_B_RESET;
        end else begin
            if (data_wr && index == IDX_STAT_A)
                stat_a_q[UIP_BIT-1:0] <= bus_wdata[UIP_BIT-1:0];
            if (data_rd && index == IDX_STAT_A)
                stat_a_q[UIP_BIT] <= ~stat_a_q[UIP_BIT];
            if (data_wr && index == IDX_STAT_B)
                stat_b_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else if (addr_rd) begin
            bus_rdata <= {index_err, 3'b000, index};
        end else if (data_rd) begin
            unique case (index)
                IDX_STAT_A:             bus_rdata <= stat_a_q;
                IDX_STAT_B:             bus_rdata <= stat_b_q;
                IDX_STAT_C, IDX_STAT_D: bus_rdata <= 8'h00;
                default:                bus_rdata <= time_byte;
            endcase
        end
    end

    // R5
    uip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && index == IDX_STAT_A) |=>
            (stat_a_q[UIP_BIT] != $past(stat_a_q[UIP_BIT])));

    // R8
    cd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (index == IDX_STAT_C || index == IDX_STAT_D)) |=>
            (bus_rdata == 8'h00));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(bus_rdata));
endmodule

// File: tb/rtc_cmos_regs_bench.sv
module rtc_cmos_regs_bench;
    localparam int DIV = 6;
    localparam logic [79:0] INIT = 80'h17_03_1C_04_11_00_0C_00_2D_00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0, bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       periodic_irq, index_err;

    int checks = 0, errors = 0;
    int cyc = 0, pulse_cnt = 0, last_pulse = -1, gap_bad = 0, width_bad = 0;
    logic prev_irq = 1'b0;
    logic uip_model = 1'b0;

    always #2.5 clk = ~clk;

    rtc_cmos_regs #(.DIV_COUNT(DIV), .TIME_INIT(INIT)) u_rtc_cmos_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periodic_irq(periodic_irq), .index_err(index_err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_irq <= periodic_irq;
        if (periodic_irq) begin
            pulse_cnt <= pulse_cnt + 1;
            if (last_pulse >= 0 && (cyc - last_pulse) != DIV) gap_bad <= gap_bad + 1;
            last_pulse <= cyc;
            if (prev_irq) width_bad <= width_bad + 1;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic port, logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_port = port; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic port, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_port = port;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", {7'b0, periodic_irq}, 8'h00);
        check("R1 err", {7'b0, index_err}, 8'h00);
        bus_read(1'b0, d); check("R1 index", d, 8'h00);
        for (int i = 0; i < 10; i++) begin
            bus_write(1'b0, 8'(i));
            bus_read(1'b1, d); check("R1 time preload", d, INIT[8*i +: 8]);
        end
        bus_write(1'b0, 8'h0B);
        bus_read(1'b1, d); check("R1 stat B", d, 8'h06);
        bus_write(1'b0, 8'h0A);
        bus_read(1'b1, d); check("R1 stat A", d, 8'h26);
        uip_model = 1'b1;
    endtask

    task automatic t_index();
        logic [7:0] d;
        bus_write(1'b0, 8'h07);
        bus_read(1'b0, d); check("R2 index 7", d, 8'h07);
        bus_write(1'b0, 8'h0D);
        bus_read(1'b0, d); check("R2 index D", d, 8'h0D);
    endtask

    task automatic t_bad_index();
        logic [7:0] d;
        bus_write(1'b0, 8'h0E);
        bus_read(1'b0, d); check("R3 index kept, err set", d, 8'h8D);
        bus_write(1'b0, 8'hF3);
        bus_write(1'b0, 8'h02);
        bus_read(1'b0, d); check("R3 err sticky", d, 8'h82);
        check("R3 err pin", {7'b0, index_err}, 8'h01);
    endtask

    task automatic t_time_bytes();
        logic [7:0] d;
        for (int i = 0; i < 10; i++) begin
            bus_write(1'b0, 8'(i));
            bus_write(1'b1, 8'(8'hA0 + i * 8'h05));
        end
        for (int i = 9; i >= 0; i--) begin
            bus_write(1'b0, 8'(i));
            bus_read(1'b1, d); check("R4 time byte", d, 8'(8'hA0 + i * 8'h05));
        end
    endtask

    task automatic t_status_a();
        logic [7:0] d;
        bus_write(1'b0, 8'h0A);
        bus_read(1'b1, d); check("R5 read A", d, {uip_model, 7'h26});
        uip_model = ~uip_model;
        bus_read(1'b1, d); check("R5 flipped A", d, {uip_model, 7'h26});
        uip_model = ~uip_model;
        bus_write(1'b1, 8'h80 | 8'h15);
        bus_read(1'b1, d); check("R6 write A low bits", d, {uip_model, 7'h15});
        uip_model = ~uip_model;
        bus_write(1'b1, 8'h26);
        bus_read(1'b1, d); check("R6 uip untouched", d, {uip_model, 7'h26});
        uip_model = ~uip_model;
    endtask

    task automatic t_status_b();
        logic [7:0] d;
        bus_write(1'b0, 8'h0B);
        bus_write(1'b1, 8'h02);
        bus_read(1'b1, d); check("R7 B byte", d, 8'h02);
        bus_write(1'b1, 8'h06);
        bus_read(1'b1, d); check("R7 B restore", d, 8'h06);
    endtask

    task automatic t_cd();
        logic [7:0] d;
        bus_write(1'b0, 8'h0C);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, d); check("R8 C zero", d, 8'h00);
        bus_write(1'b0, 8'h0D);
        bus_write(1'b1, 8'h5A);
        bus_read(1'b1, d); check("R8 D zero", d, 8'h00);
        check("R8 no irq from C/D", {7'b0, periodic_irq}, 8'h00);
    endtask

    task automatic t_periodic();
        int c0, g0, w0;
        bus_write(1'b0, 8'h0B);
        @(negedge clk); #1;
        c0 = pulse_cnt;
        repeat (4 * DIV) @(negedge clk);
        #1; check("R10 no pulse while clear", 8'(pulse_cnt - c0), 8'h00);
        bus_write(1'b1, 8'h46);
        repeat (DIV + 4) @(negedge clk);
        #1; c0 = pulse_cnt; g0 = gap_bad; w0 = width_bad;
        repeat (5 * DIV) @(negedge clk);
        #1;
        check("R9 pulse count", 8'(pulse_cnt - c0), 8'd5);
        check("R9 pulse spacing", 8'(gap_bad - g0), 8'h00);
        check("R9 pulse width", 8'(width_bad - w0), 8'h00);
    endtask

    task automatic t_coincide();
        int c0;
        while (!periodic_irq) @(negedge clk);
        repeat (DIV - 1) @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_port = 1'b1; bus_wdata = 8'h06;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        check("R10 wrap on disable edge pulses", {7'b0, periodic_irq}, 8'h01);
        @(negedge clk); #1;
        c0 = pulse_cnt;
        repeat (3 * DIV) @(negedge clk);
        #1; check("R10 stopped after disable", 8'(pulse_cnt - c0), 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        bus_write(1'b0, 8'h03);
        bus_read(1'b1, d);
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_bad_index();
        t_time_bytes();
        t_status_a();
        t_status_b();
        t_cd();
        t_periodic();
        t_coincide();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule